// File: doc/BRIEF.md
# Configuration Target with Base Address Decode

This block is the endpoint half of a configuration-space exchange. It owns a compact configuration header for one function: fixed identification words (vendor code, device code, revision and a class code naming the kind of function), a command register, and two 32-bit memory base address registers (BARs), each with a fixed power-of-two window. Configuration reads and writes carry a function number. Only requests aimed at this block's own function number reach the header. Reads aimed anywhere else return all ones, the value enumeration software takes as "nothing here".

The BARs let software size and place the windows. Writing all ones to a BAR and reading it back shows which low address bits the function decodes, because those bits always read as zero. Software then writes a base address. Once the command register's memory-enable bit is set, every memory address presented to the block is compared against both programmed windows. A match produces a hit with the BAR index and the offset inside the window. Window sizes must be at least 16 bytes, so that the four flag bits stay below the decoded range.

Top module: `cfg_bar_target`

## Requirements
- R1: After reset the command register and both BARs read as zero, and cfgAck and memHit are low.
- R2: Header dword 0 reads {device code, vendor code}, with the vendor code in bits [15:0]. Writes to it leave it unchanged.
- R3: Header dword 2 reads {class code[23:0], revision[7:0]}. Writes to it leave it unchanged.
- R4: A configuration read whose function number differs from FUNC_NUM returns 32'hFFFFFFFF. A configuration write with such a function number changes no register.
- R5: Every configuration request is answered by cfgAck exactly one cycle later. A write takes effect in time for a read issued in the following cycle.
- R6: In the command register (dword 1), only bit 1 (memory enable) and bit 2 can be written. All other bits read zero.
- R7: Writing all ones to BAR0 (dword 4) or BAR1 (dword 5) reads back ~(size-1). Bits [3:0] always read zero (32-bit, non-prefetchable memory).
- R8: cfgByteEn bit k gates byte k of a write to the command register or a BAR. Bytes that are not enabled keep their old value.
- R9: With memory enable set, a memValid address inside a window raises memHit one cycle later, with memBarIdx naming the BAR and memOffset equal to the address bits below log2(size).
- R10: With memory enable clear, no address ever raises memHit.
- R11: When both windows contain an address, BAR0 wins.
- R12: Header dwords other than 0, 1, 2, 4 and 5 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configuration request this cycle |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgFunc | input | FUNC_W | Target function number |
| cfgReg | input | REG_W | Header dword index |
| cfgByteEn | input | 4 | Byte enables for writes |
| cfgWdata | input | 32 | Write data |
| cfgAck | output | 1 | Request completed (one cycle after cfgValid) |
| cfgRdata | output | 32 | Read data, valid with cfgAck |
| memValid | input | 1 | Memory address valid this cycle |
| memAddr | input | 32 | Memory address to decode |
| memHit | output | 1 | Address fell in an enabled window |
| memBarIdx | output | 1 | Index of the matching BAR |
| memOffset | output | 32 | Offset of the address within the window |

## Verification
The assertions assume that at most one configuration request and one memory address arrive per cycle, each held for exactly one cycle. They also assume that every input is at a known value while rstN is high. The bench drives each request on the falling edge for a single cycle, and it lowers the valid of the other interface whenever it drives one. All control inputs therefore stay defined and single-cycle. The BAR window sizes used by the bench are 4 KiB and 64 KiB, which meets the assumed minimum of 16 bytes.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;

  localparam int NUM_BARS = 2;

  localparam int IDX_ID    = 0;
  localparam int IDX_CMD   = 1;
  localparam int IDX_CLASS = 2;
  localparam int IDX_BAR0  = 4;
  localparam int IDX_BAR1  = 5;

  localparam logic [15:0] CMD_WRITABLE = 16'h0006;

  typedef enum logic [2:0] {
    SEL_ID,
    SEL_CMD,
    SEL_CLASS,
    SEL_BAR0,
    SEL_BAR1,
    SEL_ZERO,
    SEL_ONES
  } rdSel_t;

  typedef struct packed {
    logic                accept;
    logic                isRead;
    logic                wrCmd;
    logic [NUM_BARS-1:0] wrBar;
    logic [3:0]          byteEn;
    rdSel_t              rdSel;
  } cfgStrobe_t;

endpackage

// File: rtl/cfgt_ctrl.sv
module cfgt_ctrl
  import cfgt_pkg::*;
#(
  parameter int FUNC_W   = 3,
  parameter int REG_W    = 6,
  parameter int FUNC_NUM = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic              cfgWrite,
  input  logic [FUNC_W-1:0] cfgFunc,
  input  logic [REG_W-1:0]  cfgReg,
  input  logic [3:0]        cfgByteEn,
  output cfgStrobe_t        strobe,
  output logic              cfgAck
);

  logic ours;
  logic doWrite;
  logic ackQ;

  assign ours    = (cfgFunc == FUNC_W'(FUNC_NUM));
  assign doWrite = cfgValid && cfgWrite && ours;

  always_comb begin
    strobe        = '0;
    strobe.accept = cfgValid;
    strobe.isRead = cfgValid && !cfgWrite;
    strobe.byteEn = cfgByteEn;
    strobe.wrCmd  = doWrite && (cfgReg == REG_W'(IDX_CMD));
    strobe.wrBar[0] = doWrite && (cfgReg == REG_W'(IDX_BAR0));
    strobe.wrBar[1] = doWrite && (cfgReg == REG_W'(IDX_BAR1));
    if (!ours)                             strobe.rdSel = SEL_ONES;
    else if (cfgReg == REG_W'(IDX_ID))     strobe.rdSel = SEL_ID;
    else if (cfgReg == REG_W'(IDX_CMD))    strobe.rdSel = SEL_CMD;
    else if (cfgReg == REG_W'(IDX_CLASS))  strobe.rdSel = SEL_CLASS;
    else if (cfgReg == REG_W'(IDX_BAR0))   strobe.rdSel = SEL_BAR0;
    else if (cfgReg == REG_W'(IDX_BAR1))   strobe.rdSel = SEL_BAR1;
    else                                   strobe.rdSel = SEL_ZERO;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= cfgValid;
  end

  assign cfgAck = ackQ;

endmodule

// File: rtl/cfgt_datapath.sv
module cfgt_datapath
  import cfgt_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID   = 16'h4A21,
  parameter logic [23:0] CLASS_CODE  = 24'h020000,
  parameter logic [7:0]  REVISION_ID = 8'h03,
  parameter int          BAR0_LOG2   = 12,
  parameter int          BAR1_LOG2   = 16,
  localparam int         IDX_W       = $clog2(NUM_BARS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       strobe,
  input  logic [31:0]      cfgWdata,
  output logic [31:0]      cfgRdata,
  input  logic             memValid,
  input  logic [31:0]      memAddr,
  output logic             memHit,
  output logic [IDX_W-1:0] memBarIdx,
  output logic [31:0]      memOffset,
  output logic             memEnable
);

  function automatic logic [31:0] mergeBytes(input logic [31:0] oldVal,
                                             input logic [31:0] newVal,
                                             input logic [3:0]  be);
    logic [31:0] res;
    res = oldVal;
    for (int b = 0; b < 4; b++)
      if (be[b]) res[b*8 +: 8] = newVal[b*8 +: 8];
    return res;
  endfunction

  // command register
  logic [15:0] cmdQ;
  logic [31:0] cmdNext;

  assign cmdNext = mergeBytes({16'h0000, cmdQ}, cfgWdata, strobe.byteEn);

  always_ff @(posedge clk) begin
    if (!rstN)             cmdQ <= '0;
    else if (strobe.wrCmd) cmdQ <= cmdNext[15:0] & CMD_WRITABLE;
  end

  assign memEnable = cmdQ[1];

  // base address registers and per-window compare
  logic [NUM_BARS-1:0][31:0] barVal;
  logic [NUM_BARS-1:0]       hitVec;
  logic [NUM_BARS-1:0][31:0] offVec;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam int          LOG2 = (i == 0) ? BAR0_LOG2 : BAR1_LOG2;
    localparam logic [31:0] KEEP = ~((32'd1 << LOG2) - 32'd1);
    logic [31:0] barQ;
    logic [31:0] barNext;

    assign barNext = mergeBytes(barQ, cfgWdata, strobe.byteEn) & KEEP;

    always_ff @(posedge clk) begin
      if (!rstN)                barQ <= '0;
      else if (strobe.wrBar[i]) barQ <= barNext;
    end

    assign barVal[i] = barQ;
    assign hitVec[i] = ((memAddr & KEEP) == barQ);
    assign offVec[i] = memAddr & ~KEEP;
  end

  // priority select: lowest index wins
  logic             selHit;
  logic [IDX_W-1:0] selIdx;
  logic [31:0]      selOff;

  always_comb begin
    selHit = 1'b0;
    selIdx = '0;
    selOff = '0;
    for (int i = NUM_BARS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selHit = 1'b1;
        selIdx = IDX_W'(i);
        selOff = offVec[i];
      end
    end
  end

  logic             hitQ;
  logic [IDX_W-1:0] idxQ;
  logic [31:0]      offQ;
  logic             hitNow;

  assign hitNow = memValid && memEnable && selHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ <= 1'b0;
      idxQ <= '0;
      offQ <= '0;
    end else begin
      hitQ <= hitNow;
      idxQ <= hitNow ? selIdx : '0;
      offQ <= hitNow ? selOff : '0;
    end
  end

  assign memHit    = hitQ;
  assign memBarIdx = idxQ;
  assign memOffset = offQ;

  // configuration read path
  logic [31:0] rdMux;
  logic [31:0] rdataQ;

  always_comb begin
    case (strobe.rdSel)
      SEL_ID:    rdMux = {DEVICE_ID, VENDOR_ID};
      SEL_CMD:   rdMux = {16'h0000, cmdQ};
      SEL_CLASS: rdMux = {CLASS_CODE, REVISION_ID};
      SEL_BAR0:  rdMux = barVal[0];
      SEL_BAR1:  rdMux = barVal[1];
      SEL_ONES:  rdMux = '1;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdataQ <= '0;
    else if (strobe.accept) rdataQ <= strobe.isRead ? rdMux : '0;
  end

  assign cfgRdata = rdataQ;

endmodule

// File: rtl/cfg_bar_target.sv
module cfg_bar_target
  import cfgt_pkg::*;
#(
  parameter int          FUNC_W      = 3,
  parameter int          REG_W       = 6,
  parameter int          FUNC_NUM    = 0,
  parameter logic [15:0] VENDOR_ID   = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID   = 16'h4A21,
  parameter logic [23:0] CLASS_CODE  = 24'h020000,
  parameter logic [7:0]  REVISION_ID = 8'h03,
  parameter int          BAR0_LOG2   = 12,
  parameter int          BAR1_LOG2   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic              cfgWrite,
  input  logic [FUNC_W-1:0] cfgFunc,
  input  logic [REG_W-1:0]  cfgReg,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWdata,
  output logic              cfgAck,
  output logic [31:0]       cfgRdata,
  input  logic              memValid,
  input  logic [31:0]       memAddr,
  output logic              memHit,
  output logic [0:0]        memBarIdx,
  output logic [31:0]       memOffset
);

  cfgStrobe_t strobe;
  logic       memEnable;

  cfgt_ctrl #(
    .FUNC_W(FUNC_W), .REG_W(REG_W), .FUNC_NUM(FUNC_NUM)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .cfgFunc(cfgFunc), .cfgReg(cfgReg), .cfgByteEn(cfgByteEn),
    .strobe(strobe), .cfgAck(cfgAck)
  );

  cfgt_datapath #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE),
    .REVISION_ID(REVISION_ID), .BAR0_LOG2(BAR0_LOG2), .BAR1_LOG2(BAR1_LOG2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .memValid(memValid), .memAddr(memAddr),
    .memHit(memHit), .memBarIdx(memBarIdx), .memOffset(memOffset),
    .memEnable(memEnable)
  );

endmodule

// File: rtl/cfg_bar_target_chk.sv
module cfg_bar_target_chk #(
  parameter int          FUNC_W    = 3,
  parameter int          REG_W     = 6,
  parameter int          FUNC_NUM  = 0,
  parameter logic [15:0] VENDOR_ID = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID = 16'h4A21,
  parameter int          BAR0_LOG2 = 12,
  parameter int          BAR1_LOG2 = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgValid,
  input logic              cfgWrite,
  input logic [FUNC_W-1:0] cfgFunc,
  input logic [REG_W-1:0]  cfgReg,
  input logic              cfgAck,
  input logic [31:0]       cfgRdata,
  input logic              memValid,
  input logic              memHit,
  input logic [0:0]        memBarIdx,
  input logic [31:0]       memOffset,
  input logic              memEnable
);

  logic ownRead;
  assign ownRead = cfgValid && !cfgWrite && (cfgFunc == FUNC_W'(FUNC_NUM));

  p_ack_follows_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgAck);

  p_no_stray_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |=> !cfgAck);

  p_foreign_ones_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !cfgWrite && (cfgFunc != FUNC_W'(FUNC_NUM))) |=> (cfgRdata == 32'hFFFF_FFFF));

  p_ident_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ownRead && (cfgReg == REG_W'(0))) |=> (cfgRdata == {DEVICE_ID, VENDOR_ID}));

  p_bar_flags_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ownRead && ((cfgReg == REG_W'(4)) || (cfgReg == REG_W'(5)))) |=> (cfgRdata[3:0] == 4'h0));

  p_hit_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    memHit |-> $past(memEnable));

  p_hit_needs_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    memHit |-> $past(memValid));

  p_offset_in_window_r9: assert property (@(posedge clk) disable iff (!rstN)
    memHit |-> ((memBarIdx == 1'b0) ? ((memOffset >> BAR0_LOG2) == 32'd0)
                                    : ((memOffset >> BAR1_LOG2) == 32'd0)));

endmodule

bind cfg_bar_target cfg_bar_target_chk #(
  .FUNC_W(FUNC_W), .REG_W(REG_W), .FUNC_NUM(FUNC_NUM),
  .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
  .BAR0_LOG2(BAR0_LOG2), .BAR1_LOG2(BAR1_LOG2)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
  .cfgFunc(cfgFunc), .cfgReg(cfgReg), .cfgAck(cfgAck), .cfgRdata(cfgRdata),
  .memValid(memValid), .memHit(memHit), .memBarIdx(memBarIdx),
  .memOffset(memOffset), .memEnable(memEnable)
);

// File: tb/cfg_bar_target_test.sv
module cfg_bar_target_test;

  localparam logic [15:0] VEN = 16'hC0DE;
  localparam logic [15:0] DEV = 16'h4A21;
  localparam logic [31:0] CLS = 32'h0200_0003;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 1'b0, cfgWrite = 1'b0;
  logic [2:0]  cfgFunc = '0;
  logic [5:0]  cfgReg = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWdata = '0;
  logic        cfgAck;
  logic [31:0] cfgRdata;
  logic        memValid = 1'b0;
  logic [31:0] memAddr = '0;
  logic        memHit;
  logic [0:0]  memBarIdx;
  logic [31:0] memOffset;

  always #5 clk = ~clk;

  cfg_bar_target uut (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .cfgFunc(cfgFunc), .cfgReg(cfgReg), .cfgByteEn(cfgByteEn),
    .cfgWdata(cfgWdata), .cfgAck(cfgAck), .cfgRdata(cfgRdata),
    .memValid(memValid), .memAddr(memAddr), .memHit(memHit),
    .memBarIdx(memBarIdx), .memOffset(memOffset)
  );

  typedef struct { logic isRead; logic [31:0] data; string req; } cfgExp_t;
  typedef struct { logic hit; logic idx; logic [31:0] off; string req; } memExp_t;
  cfgExp_t cfgQ[$];
  memExp_t memQ[$];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfgOp(input logic wr, input logic [2:0] fn, input logic [5:0] rg,
                       input logic [3:0] be, input logic [31:0] wd,
                       input logic [31:0] exp, input string req);
    @(negedge clk);
    memValid = 1'b0;
    cfgValid = 1'b1; cfgWrite = wr; cfgFunc = fn; cfgReg = rg;
    cfgByteEn = be; cfgWdata = wd;
    cfgQ.push_back('{isRead: !wr, data: exp, req: req});
  endtask

  task automatic rd(input logic [5:0] rg, input logic [31:0] exp, input string req);
    cfgOp(1'b0, 3'd0, rg, 4'hF, 32'h0, exp, req);
  endtask

  task automatic wr(input logic [5:0] rg, input logic [3:0] be, input logic [31:0] wd,
                    input string req);
    cfgOp(1'b1, 3'd0, rg, be, wd, 32'h0, req);
  endtask

  task automatic memOp(input logic [31:0] addr, input logic hit, input logic idx,
                       input logic [31:0] off, input string req);
    @(negedge clk);
    cfgValid = 1'b0;
    memValid = 1'b1; memAddr = addr;
    memQ.push_back('{hit: hit, idx: idx, off: off, req: req});
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cfgValid = 1'b0;
      memValid = 1'b0;
    end
  endtask

  // monitor: bench-side record of what was presented at each edge
  logic cfgSeen = 1'b0, memSeen = 1'b0;
  always @(posedge clk) begin
    cfgSeen <= cfgValid && rstN;
    memSeen <= memValid && rstN;
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(cfgAck === cfgSeen, "R5", "ack timing", {31'd0, cfgAck}, {31'd0, cfgSeen});
      if (cfgSeen && cfgQ.size() > 0) begin
        cfgExp_t e;
        e = cfgQ.pop_front();
        if (e.isRead) check(cfgRdata === e.data, e.req, "cfg read", cfgRdata, e.data);
      end
      if (memSeen && memQ.size() > 0) begin
        memExp_t m;
        m = memQ.pop_front();
        check(memHit === m.hit, m.req, "mem hit", {31'd0, memHit}, {31'd0, m.hit});
        if (m.hit && memHit) begin
          check(memBarIdx === m.idx, m.req, "bar index", {31'd0, memBarIdx}, {31'd0, m.idx});
          check(memOffset === m.off, m.req, "offset", memOffset, m.off);
        end
      end else if (!memSeen) begin
        check(memHit === 1'b0, "R9", "hit without address", {31'd0, memHit}, 32'd0);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL R5 watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(cfgAck === 1'b0, "R1", "ack in reset", {31'd0, cfgAck}, 32'd0);
    check(memHit === 1'b0, "R1", "hit in reset", {31'd0, memHit}, 32'd0);
    rstN = 1'b1;

    // R1: reset values
    rd(6'd1, 32'h0, "R1");
    rd(6'd4, 32'h0, "R1");
    rd(6'd5, 32'h0, "R1");
    memOp(32'h0000_0010, 1'b0, 1'b0, 32'h0, "R10");

    // R2 / R3: read-only identification
    rd(6'd0, {DEV, VEN}, "R2");
    wr(6'd0, 4'hF, 32'hFFFF_FFFF, "R2");
    rd(6'd0, {DEV, VEN}, "R2");
    rd(6'd2, CLS, "R3");
    wr(6'd2, 4'hF, 32'h1234_5678, "R3");
    rd(6'd2, CLS, "R3");

    // R12: unimplemented dwords
    rd(6'd3, 32'h0, "R12");
    wr(6'd7, 4'hF, 32'hDEAD_BEEF, "R12");
    rd(6'd7, 32'h0, "R12");
    rd(6'd63, 32'h0, "R12");

    // R7: sizing
    wr(6'd4, 4'hF, 32'hFFFF_FFFF, "R7");
    rd(6'd4, 32'hFFFF_F000, "R7");
    wr(6'd5, 4'hF, 32'hFFFF_FFFF, "R7");
    rd(6'd5, 32'hFFFF_0000, "R7");

    // R8: byte enables on BARs
    wr(6'd5, 4'b1000, 32'h1234_5678, "R8");
    rd(6'd5, 32'h12FF_0000, "R8");
    wr(6'd4, 4'hF, 32'h8000_1234, "R7");
    rd(6'd4, 32'h8000_1000, "R7");
    wr(6'd4, 4'b0100, 32'h00AB_0000, "R8");
    rd(6'd4, 32'h80AB_1000, "R8");
    wr(6'd4, 4'b0100, 32'h0000_0000, "R8");
    rd(6'd4, 32'h8000_1000, "R8");
    wr(6'd5, 4'hF, 32'h9000_0000, "R8");
    rd(6'd5, 32'h9000_0000, "R8");

    // R10: in window but decode disabled
    memOp(32'h8000_1ABC, 1'b0, 1'b0, 32'h0, "R10");

    // R6: command register
    wr(6'd1, 4'b1110, 32'hFFFF_FFFF, "R6");
    rd(6'd1, 32'h0, "R6");
    wr(6'd1, 4'hF, 32'hFFFF_FFFF, "R6");
    rd(6'd1, 32'h0000_0006, "R6");
    wr(6'd1, 4'b0001, 32'h0000_0002, "R6");
    rd(6'd1, 32'h0000_0002, "R6");

    // R4: foreign function numbers
    cfgOp(1'b0, 3'd1, 6'd0, 4'hF, 32'h0, 32'hFFFF_FFFF, "R4");
    cfgOp(1'b0, 3'd7, 6'd4, 4'hF, 32'h0, 32'hFFFF_FFFF, "R4");
    cfgOp(1'b1, 3'd2, 6'd4, 4'hF, 32'h0, 32'h0, "R4");
    cfgOp(1'b1, 3'd2, 6'd1, 4'hF, 32'h0, 32'h0, "R4");
    rd(6'd4, 32'h8000_1000, "R4");
    rd(6'd1, 32'h0000_0002, "R4");

    // R9: decode
    memOp(32'h8000_1ABC, 1'b1, 1'b0, 32'h0000_0ABC, "R9");
    memOp(32'h8000_1000, 1'b1, 1'b0, 32'h0000_0000, "R9");
    memOp(32'h8000_2000, 1'b0, 1'b0, 32'h0, "R9");
    memOp(32'h9000_FFFC, 1'b1, 1'b1, 32'h0000_FFFC, "R9");
    memOp(32'h9001_0000, 1'b0, 1'b0, 32'h0, "R9");
    memOp(32'h8FFF_FFFF, 1'b0, 1'b0, 32'h0, "R9");
    idle(1);

    // R11: overlapping windows
    wr(6'd5, 4'hF, 32'h8000_0000, "R11");
    memOp(32'h8000_1004, 1'b1, 1'b0, 32'h0000_0004, "R11");
    memOp(32'h8000_3000, 1'b1, 1'b1, 32'h0000_3000, "R11");

    // R10: disable again
    wr(6'd1, 4'hF, 32'h0, "R10");
    memOp(32'h8000_1004, 1'b0, 1'b0, 32'h0, "R10");
    memOp(32'h8000_3000, 1'b0, 1'b0, 32'h0, "R10");
    idle(4);

    check(cfgQ.size() == 0 && memQ.size() == 0, "R5", "pending responses",
          cfgQ.size() + memQ.size(), 32'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule